// File: doc/BRIEF.md
# Stream Egress Buffer with Stall Headroom

This block terminates a fixed-latency processing pipeline and presents its results on an AXI4-Stream master port. The pipeline pushes beats with a single valid strobe and has no way to pause. Each beat carries data, byte keep and strobe masks, an end-of-packet marker, a stream identifier, a routing destination and user bits. The block stores these beats in a circular buffer and releases them to the downstream consumer under the usual valid/ready handshake.

To keep the pipeline lossless without giving it a stall input, the block returns a ready signal to the stage that feeds the pipeline. That signal drops once buffer occupancy reaches a programmable stop level, which is set below the real depth. The locations between the stop level and the depth absorb every beat still travelling through the pipeline when the stop takes effect. The buffer keeps writing those beats after ready has fallen. An elaboration-time check refuses parameter sets where the headroom (depth minus stop level) does not exceed the declared pipeline latency. A separate low-water threshold drives a status output only.

Top module: `axis_egress_slack_fifo`

## Requirements
- R1: While rst_ni is low and just after it rises, m_tvalid_o, overflow_o are 0 and up_ready_o, almost_empty_o are 1.
- R2: Beats leave on the master port in arrival order, with data, keep, strobe, last, id, dest and user of each beat kept together.
- R3: m_tvalid_o is 1 exactly when the buffer holds at least one beat. While m_tvalid_o is 1 and m_tready_i is 0, every output field holds its value.
- R4: A beat is removed only in a cycle where m_tvalid_o and m_tready_i are both 1. With m_tready_i low, draining stops at once.
- R5: up_ready_o is 0 while occupancy is at or above FULL_LEVEL and 1 while occupancy is below it. It reacts in the cycle after the edge that changed occupancy.
- R6: Every beat with in_valid_i high is stored whenever the buffer is not truly full (occupancy below DEPTH), whatever the value of up_ready_o.
- R7: A cycle with both a stored push and a pop leaves occupancy unchanged.
- R8: A beat offered while occupancy equals DEPTH is discarded, leaves stored beats untouched, and sets overflow_o. overflow_o stays 1 until reset.
- R9: almost_empty_o is 1 exactly when occupancy is at most EMPTY_LEVEL. It has no effect on data flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Beat present from pipeline |
| in_data_i | input | DATA_W | Beat payload |
| in_last_i | input | 1 | End-of-packet marker |
| in_id_i | input | ID_W | Stream identifier |
| in_dest_i | input | DEST_W | Routing destination |
| in_user_i | input | USER_W | User sideband |
| in_keep_i | input | DATA_W/8 | Byte keep mask |
| in_strb_i | input | DATA_W/8 | Byte strobe mask |
| up_ready_o | output | 1 | Ready toward the pipeline ingress stage |
| m_tvalid_o | output | 1 | AXI4-Stream TVALID |
| m_tdata_o | output | DATA_W | AXI4-Stream TDATA |
| m_tlast_o | output | 1 | AXI4-Stream TLAST |
| m_tid_o | output | ID_W | AXI4-Stream TID |
| m_tdest_o | output | DEST_W | AXI4-Stream TDEST |
| m_tuser_o | output | USER_W | AXI4-Stream TUSER |
| m_tkeep_o | output | DATA_W/8 | AXI4-Stream TKEEP |
| m_tstrb_o | output | DATA_W/8 | AXI4-Stream TSTRB |
| m_tready_i | input | 1 | AXI4-Stream TREADY |
| almost_empty_o | output | 1 | Occupancy at or below EMPTY_LEVEL |
| overflow_o | output | 1 | Sticky flag: beat lost on a full buffer |

## Verification
The hardest state to reach is a truly full buffer that still receives a beat. A correct pipeline driver honours up_ready_o, so it never gets there. The bench ignores up_ready_o on purpose. It streams beats with m_tready_i held low past the stop level and up to the full depth, then offers one more. Draining afterwards shows that the stored beats came through unchanged and that the flag stays set. Simultaneous push and pop just above the stop level are checked by watching up_ready_o stay low and by counting the beats that come out afterwards.

// File: rtl/egress_pkg.sv
package egress_pkg;

  function automatic int unsigned beat_width(int unsigned data_w, int unsigned id_w,
                                             int unsigned dest_w, int unsigned user_w);
    return data_w + 2 * (data_w / 8) + id_w + dest_w + user_w + 1;
  endfunction

  function automatic int unsigned ptr_width(int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/egress_beat_pack.sv
module egress_beat_pack #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned DEST_W = 4,
  parameter int unsigned USER_W = 2,
  localparam int unsigned MASK_W = DATA_W / 8,
  localparam int unsigned BEAT_W = egress_pkg::beat_width(DATA_W, ID_W, DEST_W, USER_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [MASK_W-1:0] keep_i,
  input  logic [MASK_W-1:0] strb_i,
  input  logic              last_i,
  input  logic [ID_W-1:0]   id_i,
  input  logic [DEST_W-1:0] dest_i,
  input  logic [USER_W-1:0] user_i,
  output logic [BEAT_W-1:0] beat_o
);
  assign beat_o = {last_i, user_i, dest_i, id_i, strb_i, keep_i, data_i};
endmodule

// File: rtl/egress_beat_unpack.sv
module egress_beat_unpack #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W   = 4,
  parameter int unsigned DEST_W = 4,
  parameter int unsigned USER_W = 2,
  localparam int unsigned MASK_W = DATA_W / 8,
  localparam int unsigned BEAT_W = egress_pkg::beat_width(DATA_W, ID_W, DEST_W, USER_W)
) (
  input  logic [BEAT_W-1:0] beat_i,
  output logic [DATA_W-1:0] data_o,
  output logic [MASK_W-1:0] keep_o,
  output logic [MASK_W-1:0] strb_o,
  output logic              last_o,
  output logic [ID_W-1:0]   id_o,
  output logic [DEST_W-1:0] dest_o,
  output logic [USER_W-1:0] user_o
);
  assign {last_o, user_o, dest_o, id_o, strb_o, keep_o, data_o} = beat_i;
endmodule

// File: rtl/egress_ring.sv
module egress_ring #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PTR_W = egress_pkg::ptr_width(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [CNT_W-1:0] occ_o,
  output logic             empty_o,
  output logic             full_o
);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] occ_q;

  function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      occ_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= bump(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= bump(rd_ptr_q);
      unique case ({push_i, pop_i})
        2'b10:   occ_q <= occ_q + CNT_W'(1);
        2'b01:   occ_q <= occ_q - CNT_W'(1);
        default: occ_q <= occ_q;
      endcase
    end
  end

  assign rdata_o = mem_q[rd_ptr_q];
  assign occ_o   = occ_q;
  assign empty_o = (occ_q == '0);
  assign full_o  = (occ_q == CNT_W'(DEPTH));
endmodule

// File: rtl/egress_level_ctrl.sv
module egress_level_ctrl #(
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned FULL_LEVEL  = 12,
  parameter int unsigned EMPTY_LEVEL = 2,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] occ_i,
  input  logic             full_i,
  input  logic             in_valid_i,
  output logic             up_ready_o,
  output logic             almost_empty_o,
  output logic             overflow_o
);
  logic ovf_q;

  // lost beat: offered while every location is occupied
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   ovf_q <= 1'b0;
    else if (in_valid_i && full_i) ovf_q <= 1'b1;
  end

  assign up_ready_o     = (occ_i < CNT_W'(FULL_LEVEL));
  assign almost_empty_o = (occ_i <= CNT_W'(EMPTY_LEVEL));
  assign overflow_o     = ovf_q;
endmodule

// File: rtl/axis_egress_slack_fifo.sv
module axis_egress_slack_fifo #(
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ID_W        = 4,
  parameter int unsigned DEST_W      = 4,
  parameter int unsigned USER_W      = 2,
  parameter int unsigned DEPTH       = 16,
  parameter int unsigned FULL_LEVEL  = 12,
  parameter int unsigned EMPTY_LEVEL = 2,
  parameter int unsigned PIPE_LAT    = 3,
  localparam int unsigned MASK_W = DATA_W / 8,
  localparam int unsigned BEAT_W = egress_pkg::beat_width(DATA_W, ID_W, DEST_W, USER_W),
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  input  logic [ID_W-1:0]   in_id_i,
  input  logic [DEST_W-1:0] in_dest_i,
  input  logic [USER_W-1:0] in_user_i,
  input  logic [MASK_W-1:0] in_keep_i,
  input  logic [MASK_W-1:0] in_strb_i,
  output logic              up_ready_o,
  output logic              m_tvalid_o,
  output logic [DATA_W-1:0] m_tdata_o,
  output logic              m_tlast_o,
  output logic [ID_W-1:0]   m_tid_o,
  output logic [DEST_W-1:0] m_tdest_o,
  output logic [USER_W-1:0] m_tuser_o,
  output logic [MASK_W-1:0] m_tkeep_o,
  output logic [MASK_W-1:0] m_tstrb_o,
  input  logic              m_tready_i,
  output logic              almost_empty_o,
  output logic              overflow_o
);
  if (FULL_LEVEL > DEPTH || FULL_LEVEL == 0) begin : g_bad_level
    $error("FULL_LEVEL must lie in 1..DEPTH");
  end
  if (DEPTH - FULL_LEVEL <= PIPE_LAT) begin : g_bad_slack
    $error("headroom DEPTH-FULL_LEVEL must exceed PIPE_LAT");
  end

  logic [BEAT_W-1:0] wr_beat, rd_beat;
  logic [CNT_W-1:0]  occ;
  logic              empty, full, push, pop;

  assign push = in_valid_i && !full;
  assign pop  = !empty && m_tready_i;

  egress_beat_pack #(
    .DATA_W(DATA_W), .ID_W(ID_W), .DEST_W(DEST_W), .USER_W(USER_W)
  ) i_pack (
    .data_i(in_data_i), .keep_i(in_keep_i), .strb_i(in_strb_i), .last_i(in_last_i),
    .id_i(in_id_i), .dest_i(in_dest_i), .user_i(in_user_i), .beat_o(wr_beat)
  );

  egress_ring #(.WIDTH(BEAT_W), .DEPTH(DEPTH)) i_ring (
    .clk_i, .rst_ni,
    .push_i(push), .wdata_i(wr_beat), .pop_i(pop), .rdata_o(rd_beat),
    .occ_o(occ), .empty_o(empty), .full_o(full)
  );

  egress_level_ctrl #(
    .DEPTH(DEPTH), .FULL_LEVEL(FULL_LEVEL), .EMPTY_LEVEL(EMPTY_LEVEL)
  ) i_level (
    .clk_i, .rst_ni,
    .occ_i(occ), .full_i(full), .in_valid_i(in_valid_i),
    .up_ready_o(up_ready_o), .almost_empty_o(almost_empty_o), .overflow_o(overflow_o)
  );

  egress_beat_unpack #(
    .DATA_W(DATA_W), .ID_W(ID_W), .DEST_W(DEST_W), .USER_W(USER_W)
  ) i_unpack (
    .beat_i(rd_beat), .data_o(m_tdata_o), .keep_o(m_tkeep_o), .strb_o(m_tstrb_o),
    .last_o(m_tlast_o), .id_o(m_tid_o), .dest_o(m_tdest_o), .user_o(m_tuser_o)
  );

  assign m_tvalid_o = !empty;
endmodule

// File: rtl/egress_checker.sv
module egress_checker #(
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned FULL_LEVEL = 12,
  parameter int unsigned BEAT_W     = 8,
  parameter int unsigned CNT_W      = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              m_tvalid_o,
  input logic              m_tready_i,
  input logic              up_ready_o,
  input logic              overflow_o,
  input logic [CNT_W-1:0]  occ_i,
  input logic [BEAT_W-1:0] beat_i
);
  a_r3_hold_stalled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_tvalid_o && !m_tready_i |=> m_tvalid_o && $stable(beat_i));

  a_r4_no_drain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !m_tready_i |=> occ_i >= $past(occ_i));

  a_r5_ready_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    up_ready_o |-> occ_i < CNT_W'(FULL_LEVEL));

  a_r5_ready_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i < CNT_W'(FULL_LEVEL) |-> up_ready_o);

  a_r6_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && occ_i < CNT_W'(DEPTH) && !(m_tvalid_o && m_tready_i)
    |=> occ_i == $past(occ_i) + CNT_W'(1));

  a_r7_balanced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && occ_i < CNT_W'(DEPTH) && m_tvalid_o && m_tready_i |=> $stable(occ_i));

  a_r8_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && occ_i == CNT_W'(DEPTH) |=> overflow_o);

  a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |=> overflow_o);

  a_r8_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_i <= CNT_W'(DEPTH));
endmodule

bind axis_egress_slack_fifo egress_checker #(
  .DEPTH(DEPTH), .FULL_LEVEL(FULL_LEVEL), .BEAT_W(BEAT_W), .CNT_W(CNT_W)
) i_egress_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .in_valid_i(in_valid_i),
  .m_tvalid_o(m_tvalid_o), .m_tready_i(m_tready_i), .up_ready_o(up_ready_o),
  .overflow_o(overflow_o), .occ_i(occ), .beat_i(rd_beat)
);

// File: tb/test_axis_egress_slack_fifo.sv
module test_axis_egress_slack_fifo;
  localparam int DEPTH = 16, FULL_LEVEL = 12, EMPTY_LEVEL = 2;
  localparam int BW = 32 + 4 + 4 + 4 + 4 + 2 + 1;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic in_valid_i = 1'b0, in_last_i = 1'b0, m_tready_i = 1'b0;
  logic [31:0] in_data_i = '0;
  logic [3:0] in_id_i = '0, in_dest_i = '0, in_keep_i = '0, in_strb_i = '0;
  logic [1:0] in_user_i = '0;
  logic up_ready_o, m_tvalid_o, m_tlast_o, almost_empty_o, overflow_o;
  logic [31:0] m_tdata_o;
  logic [3:0] m_tid_o, m_tdest_o, m_tkeep_o, m_tstrb_o;
  logic [1:0] m_tuser_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] q[$];
  bit ovf_model = 0;

  always #5 clk_i = ~clk_i;

  axis_egress_slack_fifo i_axis_egress_slack_fifo (.*);

  // valid, tready, payload byte
  localparam logic [9:0] STIM [32] = '{
    {2'b10, 8'h01}, {2'b10, 8'h12}, {2'b10, 8'h23}, {2'b10, 8'h34},
    {2'b10, 8'h45}, {2'b10, 8'h56}, {2'b10, 8'h67}, {2'b10, 8'h78},
    {2'b10, 8'h89}, {2'b10, 8'h9A}, {2'b10, 8'hAB}, {2'b10, 8'hBC},
    {2'b10, 8'hCD}, {2'b10, 8'hDE}, {2'b11, 8'hEF}, {2'b11, 8'hF0},
    {2'b11, 8'h0E}, {2'b11, 8'h1D}, {2'b01, 8'h00}, {2'b01, 8'h00},
    {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00}, {2'b01, 8'h00},
    {2'b00, 8'h00}, {2'b00, 8'h00}, {2'b00, 8'h00}, {2'b00, 8'h00},
    {2'b01, 8'h00}, {2'b00, 8'h00}, {2'b01, 8'h00}, {2'b00, 8'h00}
  };

  function automatic logic [BW-1:0] expect_beat(logic [7:0] b);
    return {b[0], b[1:0], b[7:4], b[3:0], b[7:4], ~b[3:0], {4{b}}};
  endfunction

  task automatic check(string req, logic [BW-1:0] act, logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_outputs();
    check("R3 tvalid", BW'(m_tvalid_o), BW'(q.size() != 0));
    if (q.size() != 0)
      check("R2 beat fields", {m_tlast_o, m_tuser_o, m_tdest_o, m_tid_o, m_tstrb_o,
                               m_tkeep_o, m_tdata_o}, expect_beat(q[0]));
    check("R5 up_ready", BW'(up_ready_o), BW'(q.size() < FULL_LEVEL));
    check("R9 almost_empty", BW'(almost_empty_o), BW'(q.size() <= EMPTY_LEVEL));
    check("R8 overflow", BW'(overflow_o), BW'(ovf_model));
  endtask

  // checks current state, drives one cycle (R4 R6 R7 via model), waits for next negedge
  task automatic step(logic v, logic r, logic [7:0] b);
    int sz;
    check_outputs();
    in_valid_i = v; m_tready_i = r;
    in_data_i = {4{b}}; in_last_i = b[0]; in_user_i = b[1:0];
    in_dest_i = b[7:4]; in_id_i = b[3:0]; in_strb_i = b[7:4]; in_keep_i = ~b[3:0];
    sz = q.size();
    if (r && sz != 0) void'(q.pop_front());
    if (v && sz < DEPTH) q.push_back(b);
    else if (v) ovf_model = 1;
    @(negedge clk_i);
  endtask

  task automatic check_reset();
    check("R1 tvalid", BW'(m_tvalid_o), '0);
    check("R1 overflow", BW'(overflow_o), '0);
    check("R1 up_ready", BW'(up_ready_o), BW'(1));
    check("R1 almost_empty", BW'(almost_empty_o), BW'(1));
  endtask

  initial begin
    repeat (2) @(negedge clk_i);
    check_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_reset();

    // R6 R7: fill past stop level, push+pop, stalled drain
    foreach (STIM[i]) step(STIM[i][9], STIM[i][8], STIM[i][7:0]);

    // R4 R9: drain to empty
    for (int k = 0; k < 14; k++) step(1'b0, 1'b1, 8'h00);
    check("R3 empty after drain", BW'(m_tvalid_o), '0);

    // R8: fill to true full ignoring up_ready, then one extra beat
    for (int k = 0; k < DEPTH; k++) step(1'b1, 1'b0, 8'(8'h30 + k));
    step(1'b1, 1'b0, 8'hFF);
    step(1'b0, 1'b0, 8'h00);
    check("R8 overflow set", BW'(overflow_o), BW'(1));
    for (int k = 0; k < DEPTH + 2; k++) step(1'b0, 1'b1, 8'h00);
    check("R8 overflow sticky", BW'(overflow_o), BW'(1));

    // R1: reset clears sticky flag and contents
    rst_ni = 1'b0;
    q.delete(); ovf_model = 0;
    @(negedge clk_i);
    check_reset();
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_reset();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule